// File: doc/BRIEF.md
# Descriptor Transfer Controller

This block moves data between two memory locations on behalf of a processor, one activation at a time. Software loads a descriptor into the block's registers: a 24-bit source address, a 24-bit destination address, a 16-bit count, a mode byte and a few configuration bits. Loading a descriptor also arms the block. Each pulse on the activation input then makes it read a byte or a 16-bit word from the source and write that value to the destination. The transfer runs over a simple synchronous memory port with a valid/ready handshake.

The count field works in one of three ways. In normal mode it is a single 16-bit down-counter. In repeat mode and block mode it is split in two: the high byte is the reload value and the low byte is the working counter. Repeat mode cycles forever over a fixed window of addresses. Block mode moves a whole block of units for each activation. Two bits of the mode byte control what happens when the count runs out. The chain bit suppresses the end-of-count handling. The interrupt-select bit chooses between an interrupt after every activation and an interrupt only when the count is exhausted.

Top module: `desc_xfer`

## Requirements
- R1: After reset, busy, armed, cpuIrq, seqDone, addrErr and memValid are all low.
- R2: An accepted activation issues one read beat (memWrite=0) at srcNow, then one write beat (memWrite=1) at dstNow carrying the data that was read. In byte mode only bits 7:0 are meaningful; in word mode all 16 bits are. busy stays high from the first beat until the unit has been accounted for.
- R3: After each unit, each address either stays fixed or advances by the unit size (1 for a byte, 2 for a word), as its increment bit selects.
- R4: In normal mode (count-mode code 0, and code 3 behaves the same way), the 16-bit count decrements once per unit, and a loaded value of 0x0000 stands for 65,536 units. If a unit is taken while the count is 1 and chain is 0, the block disarms, pulses seqDone for one cycle and raises cpuIrq.
- R5: In repeat mode (code 1), the low byte decrements once per unit. A unit taken while the low byte is 1 reloads the low byte from the high byte and restores both addresses to their loaded values. The block stays armed, and with chain 0 it raises cpuIrq.
- R6: In block mode (code 2), one activation moves units until the low byte has counted down through 1, where 0 stands for 256 units. The low byte is then reloaded from the high byte. With chain 0 the block then disarms, pulses seqDone and raises cpuIrq.
- R7: With the chain bit (mode bit 7) set, running out of count causes no disarm, no seqDone and no count-driven cpuIrq. Counts and reloads still proceed.
- R8: With the interrupt-select bit (mode bit 6) set, cpuIrq pulses once after every completed activation.
- R9: With the interrupt-select bit clear, cpuIrq pulses only on the end-of-count events described in R4, R5 and R6.
- R10: Mode bits 5 to 0 have no effect on operation.
- R11: In word mode, an activation with an odd source or destination address pulses addrErr. It issues no memory beat and leaves the addresses, the count and the armed state unchanged.
- R12: While disarmed, activation requests are ignored. Only a new descriptor load re-arms the block.
- R13: While memReady is low, a beat stays valid with its address, direction and data held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descLoad | input | 1 | Load the descriptor fields and arm; honoured only when idle |
| descSrc | input | 24 | Source address to load |
| descDst | input | 24 | Destination address to load |
| descCount | input | 16 | Count to load (16-bit counter, or reload byte and working byte) |
| descMode | input | 8 | Mode byte: bit 7 chain, bit 6 interrupt-select, others ignored |
| descCntMode | input | 2 | 0 normal, 1 repeat, 2 block, 3 normal |
| descWord | input | 1 | 1 selects 16-bit units, 0 selects bytes |
| descSrcInc | input | 1 | 1 advances the source address after each unit |
| descDstInc | input | 1 | 1 advances the destination address after each unit |
| actReq | input | 1 | Activation request |
| busy | output | 1 | Transfer in progress |
| armed | output | 1 | Requests are accepted |
| cpuIrq | output | 1 | One-cycle interrupt request pulse |
| seqDone | output | 1 | One-cycle end-of-sequence pulse; also clears the request source |
| addrErr | output | 1 | One-cycle pulse on an odd word address |
| memValid | output | 1 | Memory beat valid |
| memWrite | output | 1 | 1 for a write beat, 0 for a read beat |
| memWord | output | 1 | Beat is 16 bits wide |
| memAddr | output | 24 | Beat address |
| memWdata | output | 16 | Write data |
| memReady | input | 1 | Memory accepts the beat this cycle |
| memRdata | input | 16 | Read data, valid with memReady on a read beat |
| srcNow | output | 24 | Current source address |
| dstNow | output | 24 | Current destination address |
| countNow | output | 16 | Current count field |

## Verification
Normal mode is tried with short counts run past exhaustion, with the 0x0000 load, with chaining, and with the spare mode bits set. These cases separate a correct end-of-count from an off-by-one, from a wrong 65,536 encoding, and from chain or spare bits leaking into the end-of-count handling. Repeat runs of several wraps show whether addresses are restored and the block stays armed. Block runs show whether a single activation moves the whole block and then disarms. Odd word addresses and requests while disarmed must leave every output and the memory untouched. A seeded random mix of modes, unit sizes, increments and memory stalls is compared against a bench model of memory, counters and pulse counts.

// File: rtl/desc_xfer_pkg.sv
package desc_xfer_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_REPEAT = 2'd1,
    CM_BLOCK  = 2'd2,
    CM_ALT    = 2'd3
  } cnt_mode_e;

  localparam int CHAIN_BIT = 7;
  localparam int ISEL_BIT  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic latchRd;
    logic step;
    logic disarm;
  } dp_strobe_t;

  // condition flags from datapath to control
  typedef struct packed {
    logic      armed;
    logic      oddWord;
    logic      unitEnds;
    logic      chainOn;
    logic      irqEvery;
    cnt_mode_e mode;
  } dp_status_t;

endpackage

// File: rtl/desc_xfer_dp.sv
module desc_xfer_dp
  import desc_xfer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [ADDR_W-1:0] descDst,
  input  logic [CNT_W-1:0]  descCount,
  input  logic [7:0]        descMode,
  input  logic [1:0]        descCntMode,
  input  logic              descWord,
  input  logic              descSrcInc,
  input  logic              descDstInc,
  input  logic              memWrite,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWord,
  output dp_status_t        status,
  output logic [ADDR_W-1:0] srcNow,
  output logic [ADDR_W-1:0] dstNow,
  output logic [CNT_W-1:0]  countNow
);

  localparam int HALF = CNT_W / 2;
  localparam int BYTE_W = 8;

  logic [ADDR_W-1:0] srcQ, dstQ, srcBaseQ, dstBaseQ;
  logic [CNT_W-1:0]  cntQ;
  logic              chainQ, iselQ, wordQ, srcIncQ, dstIncQ, armedQ;
  cnt_mode_e         modeQ;
  logic [DATA_W-1:0] dataQ;

  logic [ADDR_W-1:0] unitSize;
  logic [ADDR_W-1:0] srcAdv, dstAdv;
  logic [HALF-1:0]   hiByte, loByte;
  logic              loIsOne, fullIsOne;

  assign unitSize  = wordQ ? ADDR_W'(2) : ADDR_W'(1);
  assign srcAdv    = srcIncQ ? srcQ + unitSize : srcQ;
  assign dstAdv    = dstIncQ ? dstQ + unitSize : dstQ;
  assign hiByte    = cntQ[CNT_W-1:HALF];
  assign loByte    = cntQ[HALF-1:0];
  assign loIsOne   = (loByte == HALF'(1));
  assign fullIsOne = (cntQ == CNT_W'(1));

  always_comb begin
    status.armed    = armedQ;
    status.oddWord  = wordQ & (srcQ[0] | dstQ[0]);
    status.chainOn  = chainQ;
    status.irqEvery = iselQ;
    status.mode     = modeQ;
    case (modeQ)
      CM_REPEAT, CM_BLOCK: status.unitEnds = loIsOne;
      default:             status.unitEnds = fullIsOne;
    endcase
  end

  // descriptor registers and per-unit update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ     <= '0;
      dstQ     <= '0;
      srcBaseQ <= '0;
      dstBaseQ <= '0;
      cntQ     <= '0;
      chainQ   <= 1'b0;
      iselQ    <= 1'b0;
      wordQ    <= 1'b0;
      srcIncQ  <= 1'b0;
      dstIncQ  <= 1'b0;
      modeQ    <= CM_NORMAL;
    end else if (strobe.load) begin
      srcQ     <= descSrc;
      dstQ     <= descDst;
      srcBaseQ <= descSrc;
      dstBaseQ <= descDst;
      cntQ     <= descCount;
      chainQ   <= descMode[CHAIN_BIT];
      iselQ    <= descMode[ISEL_BIT];
      wordQ    <= descWord;
      srcIncQ  <= descSrcInc;
      dstIncQ  <= descDstInc;
      modeQ    <= cnt_mode_e'(descCntMode);
    end else if (strobe.step) begin
      case (modeQ)
        CM_REPEAT: begin
          if (loIsOne) begin
            cntQ[HALF-1:0] <= hiByte;
            srcQ           <= srcBaseQ;
            dstQ           <= dstBaseQ;
          end else begin
            cntQ[HALF-1:0] <= loByte - HALF'(1);
            srcQ           <= srcAdv;
            dstQ           <= dstAdv;
          end
        end
        CM_BLOCK: begin
          cntQ[HALF-1:0] <= loIsOne ? hiByte : loByte - HALF'(1);
          srcQ           <= srcAdv;
          dstQ           <= dstAdv;
        end
        default: begin
          cntQ <= cntQ - CNT_W'(1);
          srcQ <= srcAdv;
          dstQ <= dstAdv;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else if (strobe.load) armedQ <= 1'b1;
    else if (strobe.disarm) armedQ <= 1'b0;
  end

  // read data latch: bytes are zero-extended
  generate
    if (DATA_W > BYTE_W) begin : g_wide
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dataQ <= '0;
        else if (strobe.latchRd)
          dataQ <= wordQ ? memRdata : {{(DATA_W-BYTE_W){1'b0}}, memRdata[BYTE_W-1:0]};
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dataQ <= '0;
        else if (strobe.latchRd) dataQ <= memRdata;
      end
    end
  endgenerate

  assign memAddr  = memWrite ? dstQ : srcQ;
  assign memWdata = dataQ;
  assign memWord  = wordQ;
  assign srcNow   = srcQ;
  assign dstNow   = dstQ;
  assign countNow = cntQ;

endmodule

// File: rtl/desc_xfer_ctrl.sv
module desc_xfer_ctrl
  import desc_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descLoad,
  input  logic       actReq,
  input  logic       memReady,
  input  dp_status_t status,
  output dp_strobe_t strobe,
  output logic       memValid,
  output logic       memWrite,
  output logic       busy,
  output logic       cpuIrq,
  output logic       seqDone,
  output logic       addrErr
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_STEP  = 2'd3
  } state_e;

  state_e stateQ, stateD;
  logic   irqQ, doneQ, errQ;
  logic   moreInBlock, countEvent, endHit, irqHit, startOk, startBad;

  assign startOk  = (stateQ == ST_IDLE) & actReq & status.armed & ~status.oddWord;
  assign startBad = (stateQ == ST_IDLE) & actReq & status.armed &  status.oddWord;

  assign moreInBlock = (status.mode == CM_BLOCK) & ~status.unitEnds;
  assign countEvent  = status.unitEnds & ~status.chainOn;
  assign endHit      = (stateQ == ST_STEP) & countEvent & (status.mode != CM_REPEAT);
  assign irqHit      = (stateQ == ST_STEP) & ~moreInBlock & (status.irqEvery | countEvent);

  always_comb begin
    stateD         = stateQ;
    strobe         = '0;
    memValid       = 1'b0;
    memWrite       = 1'b0;
    strobe.load    = descLoad & (stateQ == ST_IDLE);
    strobe.disarm  = endHit;
    case (stateQ)
      ST_IDLE: if (startOk) stateD = ST_READ;
      ST_READ: begin
        memValid = 1'b1;
        if (memReady) begin
          strobe.latchRd = 1'b1;
          stateD         = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) stateD = ST_STEP;
      end
      default: begin
        strobe.step = 1'b1;
        stateD      = moreInBlock ? ST_READ : ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      irqQ   <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      irqQ   <= irqHit;
      doneQ  <= endHit;
      errQ   <= startBad;
    end
  end

  assign busy    = (stateQ != ST_IDLE);
  assign cpuIrq  = irqQ;
  assign seqDone = doneQ;
  assign addrErr = errQ;

endmodule

// File: rtl/desc_xfer.sv
module desc_xfer
  import desc_xfer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descLoad,
  input  logic [ADDR_W-1:0] descSrc,
  input  logic [ADDR_W-1:0] descDst,
  input  logic [CNT_W-1:0]  descCount,
  input  logic [7:0]        descMode,
  input  logic [1:0]        descCntMode,
  input  logic              descWord,
  input  logic              descSrcInc,
  input  logic              descDstInc,
  input  logic              actReq,
  output logic              busy,
  output logic              armed,
  output logic              cpuIrq,
  output logic              seqDone,
  output logic              addrErr,
  output logic              memValid,
  output logic              memWrite,
  output logic              memWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcNow,
  output logic [ADDR_W-1:0] dstNow,
  output logic [CNT_W-1:0]  countNow
);

  dp_strobe_t strobe;
  dp_status_t status;

  desc_xfer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .descLoad (descLoad),
    .actReq   (actReq),
    .memReady (memReady),
    .status   (status),
    .strobe   (strobe),
    .memValid (memValid),
    .memWrite (memWrite),
    .busy     (busy),
    .cpuIrq   (cpuIrq),
    .seqDone  (seqDone),
    .addrErr  (addrErr)
  );

  desc_xfer_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .descSrc     (descSrc),
    .descDst     (descDst),
    .descCount   (descCount),
    .descMode    (descMode),
    .descCntMode (descCntMode),
    .descWord    (descWord),
    .descSrcInc  (descSrcInc),
    .descDstInc  (descDstInc),
    .memWrite    (memWrite),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .memWord     (memWord),
    .status      (status),
    .srcNow      (srcNow),
    .dstNow      (dstNow),
    .countNow    (countNow)
  );

  assign armed = status.armed;

endmodule

// File: rtl/desc_xfer_chk.sv
module desc_xfer_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              armed,
  input logic              seqDone,
  input logic              addrErr,
  input logic              memValid,
  input logic              memWrite,
  input logic              memWord,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata
);

  AST_BEAT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> busy);  // R2

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWord) |-> !memAddr[0]);  // R11

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !armed);  // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);  // R6

  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> !busy);  // R11

  AST_DISARMED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !busy) |=> !busy);  // R12

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)));  // R13

endmodule

bind desc_xfer desc_xfer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .armed    (armed),
  .seqDone  (seqDone),
  .addrErr  (addrErr),
  .memValid (memValid),
  .memWrite (memWrite),
  .memWord  (memWord),
  .memReady (memReady),
  .memAddr  (memAddr),
  .memWdata (memWdata)
);

// File: tb/desc_xfer_bench.sv
`timescale 1ns/1ps
module desc_xfer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descLoad = 1'b0;
  logic [23:0] descSrc = '0, descDst = '0;
  logic [15:0] descCount = '0;
  logic [7:0]  descMode = '0;
  logic [1:0]  descCntMode = '0;
  logic        descWord = 1'b0, descSrcInc = 1'b0, descDstInc = 1'b0;
  logic        actReq = 1'b0;
  logic        busy, armed, cpuIrq, seqDone, addrErr;
  logic        memValid, memWrite, memWord;
  logic [23:0] memAddr;
  logic [15:0] memWdata;
  logic        memReady = 1'b0;
  logic [15:0] memRdata;
  logic [23:0] srcNow, dstNow;
  logic [15:0] countNow;

  always #2 clk = ~clk;  // 250 MHz

  desc_xfer u_desc_xfer (.*);

  // memory model
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [7:0] rdLo, rdHi;
  assign rdLo = memAddr[7:0];
  assign rdHi = memAddr[7:0] + 8'd1;
  assign memRdata = {mem[rdHi], mem[rdLo]};

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (memValid && memReady && memWrite) begin
      mem[rdLo] <= memWdata[7:0];
      if (memWord) mem[rdHi] <= memWdata[15:8];
    end
  end

  always @(negedge clk) memReady <= ($urandom % 4) != 0;

  int irqSeen = 0, doneSeen = 0, errSeen = 0, beatSeen = 0;
  always @(posedge clk) begin
    if (rstN) begin
      if (cpuIrq) irqSeen++;
      if (seqDone) doneSeen++;
      if (addrErr) errSeen++;
      if (memValid && memReady && memWrite) beatSeen++;
    end
  end

  int checks = 0, fails = 0;
  int cycles = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: act=%0d exp=%0d cycles", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // bench model of the descriptor
  logic [23:0] mSrc, mDst, mSrc0, mDst0;
  logic [15:0] mCnt;
  logic [1:0]  mCm;
  bit mChain, mIsel, mWord, mSi, mDi, mArmed = 0;
  int expIrq = 0, expDone = 0, expErr = 0, expBeat = 0;

  task automatic modelAct();
    bit ends, more;
    logic [7:0] s, d, step;
    if (!mArmed) return;
    if (mWord && (mSrc[0] || mDst[0])) begin expErr++; return; end
    step = mWord ? 8'd2 : 8'd1;
    more = 1;
    ends = 0;
    while (more) begin
      logic [7:0] b0, b1;
      s = mSrc[7:0]; d = mDst[7:0];
      b0 = expMem[s]; b1 = expMem[8'(s + 8'd1)];
      expMem[d] = b0;
      if (mWord) expMem[8'(d + 8'd1)] = b1;
      expBeat++;
      if (mCm == 2'd1 || mCm == 2'd2) ends = (mCnt[7:0] == 8'd1);
      else ends = (mCnt == 16'd1);
      if (mCm == 2'd1 && ends) begin
        mCnt[7:0] = mCnt[15:8]; mSrc = mSrc0; mDst = mDst0;
      end else begin
        if (mCm == 2'd1 || mCm == 2'd2) mCnt[7:0] = ends ? mCnt[15:8] : mCnt[7:0] - 8'd1;
        else mCnt = mCnt - 16'd1;
        if (mSi) mSrc = mSrc + 24'(step);
        if (mDi) mDst = mDst + 24'(step);
      end
      more = (mCm == 2'd2) && !ends;
    end
    if (mIsel || (ends && !mChain)) expIrq++;
    if (ends && !mChain && mCm != 2'd1) begin expDone++; mArmed = 0; end
  endtask

  task automatic loadDesc(logic [23:0] s, logic [23:0] d, logic [15:0] c,
                          logic [7:0] m, logic [1:0] cm, bit w, bit si, bit di);
    @(negedge clk);
    descSrc = s; descDst = d; descCount = c; descMode = m; descCntMode = cm;
    descWord = w; descSrcInc = si; descDstInc = di; descLoad = 1'b1;
    @(negedge clk);
    descLoad = 1'b0;
    mSrc = s; mDst = d; mSrc0 = s; mDst0 = d; mCnt = c; mCm = cm;
    mChain = m[7]; mIsel = m[6]; mWord = w; mSi = si; mDi = di; mArmed = 1;
  endtask

  task automatic activate(string cntTag);
    int guard = 0;
    @(negedge clk);
    actReq = 1'b1;
    @(negedge clk);
    actReq = 1'b0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    @(negedge clk);
    @(negedge clk);
    modelAct();
    check(cntTag, "count", countNow, mCnt);
    check("R3", "source address", srcNow, mSrc);
    check("R3", "destination address", dstNow, mDst);
    check(mChain ? "R7" : "R4", "armed", armed, mArmed);
    check(mIsel ? "R8" : "R9", "interrupt pulses", irqSeen, expIrq);
    check(mChain ? "R7" : "R6", "done pulses", doneSeen, expDone);
    check("R11", "address error pulses", errSeen, expErr);
    check("R2 R13", "write beats", beatSeen, expBeat);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) bad++;
      check("R2", "memory mismatches", bad, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    for (int i = 0; i < 256; i++) expMem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "armed", armed, 0);
    check("R1", "irq/done/err", {cpuIrq, seqDone, addrErr}, 0);
    check("R1", "memValid", memValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R12 request before any load is ignored
    activate("R12");

    // R4 normal byte, count 3, then a fourth request is ignored (R12)
    loadDesc(24'h000010, 24'h000080, 16'd3, 8'h00, 2'd0, 0, 1, 1);
    repeat (3) activate("R4");
    activate("R12");

    // R4 count 0x0000 means 65,536
    loadDesc(24'h000020, 24'h000090, 16'h0000, 8'h00, 2'd0, 1, 1, 1);
    activate("R4");

    // R7 chain with count 1, interrupt every activation (R8)
    loadDesc(24'h000030, 24'h0000A0, 16'd1, 8'hC0, 2'd0, 0, 1, 0);
    activate("R7");
    activate("R7");

    // R10 spare mode bits set, code 3 acts as normal
    loadDesc(24'h000040, 24'h0000B0, 16'd1, 8'h3F, 2'd3, 0, 0, 1);
    activate("R10");

    // R5 repeat, hi=3 lo=3, several wraps
    loadDesc(24'h000050, 24'h0000C0, 16'h0303, 8'h00, 2'd1, 0, 1, 1);
    repeat (7) activate("R5");

    // R6 block word, hi=4 lo=4
    loadDesc(24'h000060, 24'h0000D0, 16'h0404, 8'h00, 2'd2, 1, 1, 1);
    activate("R6");
    activate("R12");

    // R11 odd word address
    loadDesc(24'h000071, 24'h0000E0, 16'd2, 8'h00, 2'd0, 1, 1, 1);
    activate("R11");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] cm;
      logic [15:0] c;
      logic [7:0] m;
      bit w;
      cm = 2'($urandom % 4);
      w  = 1'($urandom % 2);
      m  = 8'($urandom);
      if (cm == 2'd1 || cm == 2'd2)
        c = {8'(1 + $urandom % 4), 8'(1 + $urandom % 4)};
      else
        c = 16'(1 + $urandom % 5);
      loadDesc({16'h0, 8'($urandom)} & {23'h7FFFFF, ($urandom % 5) != 0 ? ~w : 1'b1},
               {16'h0, 8'($urandom)} & {23'h7FFFFF, ~w},
               c, m, cm, w, 1'($urandom % 2), 1'($urandom % 2));
      for (int k = 0; k < int'(1 + $urandom % 6); k++)
        activate(cm == 2'd1 ? "R5" : (cm == 2'd2 ? "R6" : "R4"));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule